// File: doc/BRIEF.md
# Network Interface Ordering Controller

This block sits on the source side of a network interface, between a processing unit's command port and the logic that builds request packets. It decides, cycle by cycle, whether a command may go out. Several reads may be in flight together only while they all target one destination. Because every destination is reached over a single fixed path, replies arrive in issue order without sequence numbers or a reorder buffer. A command to any other destination waits until the outstanding count falls back to zero.

Each accepted command becomes one or more request headers on a registered header stream. Burst writes mark every packet except the final one with a hold bit. Switches use that bit to keep their grant fixed, so the burst cannot be split by other traffic. Only one burst read flow may be active at a time. A saturating counter of outstanding read packets also limits how many reads are in flight.

Top module: `nif_order_ctrl`

## Requirements
- R1: After reset, `hdr_valid` is low and `cmd_ready` is high, because no transaction is outstanding.
- R2: `cmd_kind` uses this encoding: 2'b00 single read, 2'b01 single write, 2'b10 burst read, 2'b11 burst write. An accepted command (`cmd_valid` and `cmd_ready` high at a rising edge) places its first header on the outputs in the following cycle, carrying the command's kind and destination.
- R3: For burst kinds, `cmd_len` gives the packet count minus one. For single kinds it is ignored and exactly one packet is sent. Burst packets leave on consecutive cycles, and `cmd_ready` stays low until the last packet has been sent.
- R4: A read may issue while earlier reads are outstanding if it targets the same destination as those reads.
- R5: Any command whose destination differs from the outstanding reads' destination is held with `cmd_ready` low. It is accepted in the first cycle in which the outstanding count is zero.
- R6: Every burst-write packet except the last has `hdr_hold` = 1, and the last burst-write packet has `hdr_hold` = 0.
- R7: Single reads, single writes and all burst-read packets have `hdr_hold` = 0.
- R8: A new burst read is held until the previous burst read has sent all its packets and the outstanding count has returned to zero.
- R9: Each read packet sent adds one to the outstanding count, and each `rsp_done` pulse takes one away. At `MAX_OUT`, new reads and further burst-read packets stall. Writes are not limited by the count.
- R10: An `rsp_done` pulse while the count is zero is ignored, so the count does not wrap.
- R11: `hdr_last` is high on the final header of every command, and on the only header of a single command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | A command is presented |
| cmd_ready | output | 1 | The command may be accepted this cycle |
| cmd_kind | input | 2 | Command kind (encoding in R2) |
| cmd_dest | input | DEST_W | Destination node |
| cmd_len | input | LEN_W | Burst packet count minus one |
| rsp_done | input | 1 | One outstanding read transaction has completed |
| hdr_valid | output | 1 | A header is emitted this cycle |
| hdr_kind | output | 2 | Kind of the emitted packet |
| hdr_dest | output | DEST_W | Destination of the emitted packet |
| hdr_hold | output | 1 | Switches keep their grant after this packet |
| hdr_last | output | 1 | Final packet of its command |

## Verification
The hardest state to reach is a burst read that stalls partway through its packets because the outstanding count has hit its limit, and then resumes as completions arrive. At the same time, a second burst read or a read to a different destination must stay blocked. The stimulus reaches this with a burst longer than `MAX_OUT` and completions withheld, then releases one completion per cycle. A random phase then mixes kinds, a small set of destinations and sparse completions. A behavioural model built on a packet queue predicts ready and every header on every cycle.

// File: rtl/nif_order_pkg.sv
package nif_order_pkg;

   typedef enum logic [1:0] {
      KIND_RD  = 2'b00,
      KIND_WR  = 2'b01,
      KIND_BRD = 2'b10,
      KIND_BWR = 2'b11
   } nif_kind_e;

   function automatic logic kind_is_read(nif_kind_e k);
      return (k == KIND_RD) || (k == KIND_BRD);
   endfunction

   function automatic logic kind_is_burst(nif_kind_e k);
      return (k == KIND_BRD) || (k == KIND_BWR);
   endfunction

endpackage

// File: rtl/nif_txn_tracker.sv
module nif_txn_tracker
   import nif_order_pkg::*;
#(
   parameter int DEST_W  = 3,
   parameter int MAX_OUT = 4,
   parameter int CNT_W   = $clog2(MAX_OUT + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              inc,
   input  logic [DEST_W-1:0] inc_dest,
   input  logic              done,
   input  logic              brd_start,
   input  logic              seq_busy,
   output logic              live,
   output logic              full,
   output logic [DEST_W-1:0] grp_dest,
   output logic              brd_flow
);

   logic [CNT_W-1:0]  cnt_q;
   logic [CNT_W-1:0]  cnt_d;
   logic [DEST_W-1:0] grp_q;
   logic              brd_q;
   logic              dec;

   assign dec = done && (cnt_q != '0);

   generate
      if (MAX_OUT == 1) begin : g_flag
         assign cnt_d = (inc || ((cnt_q != '0) && !dec)) ? CNT_W'(1) : '0;
      end else begin : g_count
         always_comb begin
            case ({inc, dec})
               2'b10:   cnt_d = cnt_q + CNT_W'(1);
               2'b01:   cnt_d = cnt_q - CNT_W'(1);
               default: cnt_d = cnt_q;
            endcase
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         grp_q <= '0;
         brd_q <= 1'b0;
      end else begin
         cnt_q <= cnt_d;
         if (cnt_d == '0) begin
            grp_q <= '0;
         end else if (inc && (cnt_q == '0)) begin
            grp_q <= inc_dest;
         end
         if (brd_start) begin
            brd_q <= 1'b1;
         end else if ((cnt_q == '0) && !seq_busy) begin
            brd_q <= 1'b0;
         end
      end
   end

   assign live     = (cnt_q != '0);
   assign full     = (cnt_q == CNT_W'(MAX_OUT));
   assign grp_dest = grp_q;
   assign brd_flow = brd_q && !((cnt_q == '0) && !seq_busy);

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= CNT_W'(MAX_OUT)); // R9
   AST_INC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      inc && !done |=> cnt_q == $past(cnt_q) + CNT_W'(1)); // R9
   AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q == '0) && done && !inc |=> cnt_q == '0); // R10

endmodule

// File: rtl/nif_issue_gate.sv
module nif_issue_gate
   import nif_order_pkg::*;
#(
   parameter int DEST_W = 3
) (
   input  nif_kind_e         kind,
   input  logic [DEST_W-1:0] dest,
   input  logic              seq_busy,
   input  logic              live,
   input  logic [DEST_W-1:0] grp_dest,
   input  logic              full,
   input  logic              brd_flow,
   output logic              ok
);

   logic dest_ok;
   logic room_ok;
   logic flow_ok;

   always_comb begin
      dest_ok = !live || (dest == grp_dest);
      room_ok = !(kind_is_read(kind) && full);
      flow_ok = !((kind == KIND_BRD) && brd_flow);
      ok      = !seq_busy && dest_ok && room_ok && flow_ok;
   end

endmodule

// File: rtl/nif_pkt_seq.sv
module nif_pkt_seq
   import nif_order_pkg::*;
#(
   parameter int DEST_W = 3,
   parameter int LEN_W  = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              accept,
   input  nif_kind_e         acc_kind,
   input  logic [DEST_W-1:0] acc_dest,
   input  logic [LEN_W-1:0]  acc_len,
   input  logic              full,
   output logic              busy,
   output logic              fire,
   output nif_kind_e         fire_kind,
   output logic [DEST_W-1:0] fire_dest,
   output logic              hdr_valid,
   output nif_kind_e         hdr_kind,
   output logic [DEST_W-1:0] hdr_dest,
   output logic              hdr_hold,
   output logic              hdr_last
);

   logic              busy_q;
   logic [LEN_W-1:0]  rem_q;
   nif_kind_e         cur_kind_q;
   logic [DEST_W-1:0] cur_dest_q;
   logic [LEN_W-1:0]  first_len;
   logic              cont;
   logic              fire_last;
   logic              fire_hold;

   always_comb begin
      first_len = kind_is_burst(acc_kind) ? acc_len : '0;
      cont      = busy_q && !((cur_kind_q == KIND_BRD) && full);
      fire      = accept || cont;
      fire_kind = accept ? acc_kind : cur_kind_q;
      fire_dest = accept ? acc_dest : cur_dest_q;
      fire_last = accept ? (first_len == '0) : (rem_q == LEN_W'(1));
      fire_hold = (fire_kind == KIND_BWR) && !fire_last;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q     <= 1'b0;
         rem_q      <= '0;
         cur_kind_q <= KIND_RD;
         cur_dest_q <= '0;
         hdr_valid  <= 1'b0;
         hdr_kind   <= KIND_RD;
         hdr_dest   <= '0;
         hdr_hold   <= 1'b0;
         hdr_last   <= 1'b0;
      end else begin
         hdr_valid <= fire;
         if (fire) begin
            hdr_kind <= fire_kind;
            hdr_dest <= fire_dest;
            hdr_hold <= fire_hold;
            hdr_last <= fire_last;
         end
         if (accept && (first_len != '0)) begin
            busy_q     <= 1'b1;
            rem_q      <= first_len;
            cur_kind_q <= acc_kind;
            cur_dest_q <= acc_dest;
         end else if (cont) begin
            rem_q <= rem_q - LEN_W'(1);
            if (rem_q == LEN_W'(1)) begin
               busy_q <= 1'b0;
            end
         end
      end
   end

   assign busy = busy_q;

   AST_HOLD_NOT_LAST: assert property (@(posedge clk) disable iff (!rst_n)
      hdr_valid && hdr_hold |-> !hdr_last); // R6
   AST_HOLD_ONLY_BWR: assert property (@(posedge clk) disable iff (!rst_n)
      hdr_valid && (hdr_kind != KIND_BWR) |-> !hdr_hold); // R7
   AST_BURST_BACK2BACK: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q && (cur_kind_q != KIND_BRD) |=> hdr_valid); // R3
   AST_NO_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q |-> !accept); // R3

endmodule

// File: rtl/nif_order_ctrl.sv
module nif_order_ctrl
   import nif_order_pkg::*;
#(
   parameter int DEST_W  = 3,
   parameter int LEN_W   = 3,
   parameter int MAX_OUT = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   output logic              cmd_ready,
   input  logic [1:0]        cmd_kind,
   input  logic [DEST_W-1:0] cmd_dest,
   input  logic [LEN_W-1:0]  cmd_len,
   input  logic              rsp_done,
   output logic              hdr_valid,
   output logic [1:0]        hdr_kind,
   output logic [DEST_W-1:0] hdr_dest,
   output logic              hdr_hold,
   output logic              hdr_last
);

   localparam int CNT_W = $clog2(MAX_OUT + 1);

   generate
      if (DEST_W < 1) begin : g_bad_dest
         $error("DEST_W must be at least 1");
      end
      if (LEN_W < 1) begin : g_bad_len
         $error("LEN_W must be at least 1");
      end
      if (MAX_OUT < 1) begin : g_bad_max
         $error("MAX_OUT must be at least 1");
      end
   endgenerate

   nif_kind_e         kind;
   nif_kind_e         fire_kind;
   nif_kind_e         hdr_kind_e;
   logic [DEST_W-1:0] fire_dest;
   logic [DEST_W-1:0] grp_dest;
   logic              accept;
   logic              fire;
   logic              seq_busy;
   logic              live;
   logic              full;
   logic              brd_flow;
   logic              inc;
   logic              gate_ok;

   assign kind      = nif_kind_e'(cmd_kind);
   assign cmd_ready = gate_ok;
   assign accept    = cmd_valid && gate_ok;
   assign inc       = fire && kind_is_read(fire_kind);
   assign hdr_kind  = hdr_kind_e;

   nif_issue_gate #(.DEST_W(DEST_W)) i_gate (
      .kind     (kind),
      .dest     (cmd_dest),
      .seq_busy (seq_busy),
      .live     (live),
      .grp_dest (grp_dest),
      .full     (full),
      .brd_flow (brd_flow),
      .ok       (gate_ok)
   );

   nif_txn_tracker #(.DEST_W(DEST_W), .MAX_OUT(MAX_OUT), .CNT_W(CNT_W)) i_tracker (
      .clk       (clk),
      .rst_n     (rst_n),
      .inc       (inc),
      .inc_dest  (fire_dest),
      .done      (rsp_done),
      .brd_start (accept && (kind == KIND_BRD)),
      .seq_busy  (seq_busy),
      .live      (live),
      .full      (full),
      .grp_dest  (grp_dest),
      .brd_flow  (brd_flow)
   );

   nif_pkt_seq #(.DEST_W(DEST_W), .LEN_W(LEN_W)) i_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .accept    (accept),
      .acc_kind  (kind),
      .acc_dest  (cmd_dest),
      .acc_len   (cmd_len),
      .full      (full),
      .busy      (seq_busy),
      .fire      (fire),
      .fire_kind (fire_kind),
      .fire_dest (fire_dest),
      .hdr_valid (hdr_valid),
      .hdr_kind  (hdr_kind_e),
      .hdr_dest  (hdr_dest),
      .hdr_hold  (hdr_hold),
      .hdr_last  (hdr_last)
   );

   AST_DEST_GROUP: assert property (@(posedge clk) disable iff (!rst_n)
      hdr_valid && kind_is_read(hdr_kind_e) && $past(live) |-> hdr_dest == $past(grp_dest)); // R5
   AST_READ_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
      full && !rsp_done |=> !(hdr_valid && kind_is_read(hdr_kind_e))); // R9

endmodule

// File: tb/test_nif_order_ctrl.sv
module test_nif_order_ctrl;

   localparam int DW = 3;
   localparam int LW = 3;
   localparam int MO = 4;
   localparam int K_RD = 0, K_WR = 1, K_BRD = 2, K_BWR = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cmd_valid = 1'b0;
   logic          cmd_ready;
   logic [1:0]    cmd_kind = '0;
   logic [DW-1:0] cmd_dest = '0;
   logic [LW-1:0] cmd_len = '0;
   logic          rsp_done = 1'b0;
   logic          hdr_valid;
   logic [1:0]    hdr_kind;
   logic [DW-1:0] hdr_dest;
   logic          hdr_hold;
   logic          hdr_last;

   always #10 clk = ~clk;

   nif_order_ctrl #(.DEST_W(DW), .LEN_W(LW), .MAX_OUT(MO)) i_nif_order_ctrl (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
      .cmd_kind(cmd_kind), .cmd_dest(cmd_dest), .cmd_len(cmd_len),
      .rsp_done(rsp_done), .hdr_valid(hdr_valid), .hdr_kind(hdr_kind),
      .hdr_dest(hdr_dest), .hdr_hold(hdr_hold), .hdr_last(hdr_last)
   );

   int checks = 0;
   int errors = 0;
   int vcount = 0;

   // behavioural reference: packet = kind | dest<<2 | hold<<8 | last<<9
   int m_cnt = 0;
   int m_grp = 0;
   bit m_brd = 0;
   int pend[$];
   bit e_valid = 0;
   int e_kind = 0, e_dest = 0, e_hold = 0, e_last = 0;

   task automatic chk(bit ok, string tag, int act, int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   function automatic bit m_ready(int k, int d);
      bit rd = (k == K_RD) || (k == K_BRD);
      if (pend.size() != 0) return 0;
      if (m_cnt != 0 && d != m_grp) return 0;
      if (rd && m_cnt >= MO) return 0;
      if (k == K_BRD && m_brd && m_cnt != 0) return 0;
      return 1;
   endfunction

   function automatic int mkpkt(int k, int d, int hold, int last);
      return k | (d << 2) | (hold << 8) | (last << 9);
   endfunction

   task automatic step(bit v, int k, int d, int l, bit done, output bit acc);
      int pkt;
      bit pe;
      bit inc, dec;
      int nc;
      bit er;
      cmd_valid = v;
      cmd_kind  = 2'(k);
      cmd_dest  = DW'(d);
      cmd_len   = LW'(l);
      rsp_done  = done;
      #1;
      er = m_ready(k, d);
      if (v) chk(cmd_ready == er, (k == K_BRD) ? "R8 ready" : "R5 ready", cmd_ready, er);
      acc = v && er;
      @(posedge clk);
      pkt = -1;
      pe = (pend.size() == 0);
      if (acc) begin
         bit burst = (k == K_BRD) || (k == K_BWR);
         int n = burst ? l : 0;
         pkt = mkpkt(k, d, (k == K_BWR && n != 0) ? 1 : 0, (n == 0) ? 1 : 0);
         for (int i = 1; i <= n; i++)
            pend.push_back(mkpkt(k, d, (k == K_BWR && i != n) ? 1 : 0, (i == n) ? 1 : 0));
      end else if (!pe) begin
         if (!(((pend[0] & 3) == K_BRD) && m_cnt >= MO)) pkt = pend.pop_front();
      end
      inc = (pkt >= 0) && (((pkt & 3) == K_RD) || ((pkt & 3) == K_BRD));
      dec = done && (m_cnt > 0);
      nc = m_cnt + (inc ? 1 : 0) - (dec ? 1 : 0);
      if (nc == 0) m_grp = 0;
      else if (inc && m_cnt == 0) m_grp = (pkt >> 2) & 63;
      if (acc && k == K_BRD) m_brd = 1;
      else if (m_cnt == 0 && pe) m_brd = 0;
      m_cnt = nc;
      e_valid = (pkt >= 0);
      if (e_valid) begin
         e_kind = pkt & 3; e_dest = (pkt >> 2) & 63;
         e_hold = (pkt >> 8) & 1; e_last = (pkt >> 9) & 1;
      end
      @(negedge clk);
      chk(hdr_valid == e_valid, "R3 valid", hdr_valid, e_valid);
      if (hdr_valid) vcount++;
      if (e_valid && hdr_valid) begin
         chk(hdr_kind == 2'(e_kind), "R2 kind", hdr_kind, e_kind);
         chk(hdr_dest == DW'(e_dest), "R2 dest", hdr_dest, e_dest);
         chk(hdr_hold == e_hold[0], (e_kind == K_BWR) ? "R6 hold" : "R7 hold", hdr_hold, e_hold);
         chk(hdr_last == e_last[0], "R11 last", hdr_last, e_last);
      end
   endtask

   task automatic send(int k, int d, int l, int done_every, output int stalls);
      bit a = 0;
      stalls = 0;
      while (!a && stalls < 1000) begin
         step(1, k, d, l, (done_every != 0) && ((stalls % done_every) == done_every - 1), a);
         if (!a) stalls++;
      end
   endtask

   task automatic idle(int n, bit done);
      bit a;
      for (int i = 0; i < n; i++) step(0, 0, 0, 0, done, a);
   endtask

   initial begin
      #4000000;
      checks++;
      errors++;
      $display("FAIL watchdog: actual 0 expected 1 (run did not complete)");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      int s;
      bit a;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      chk(hdr_valid == 1'b0, "R1 hdr_valid", hdr_valid, 0);
      chk(cmd_ready == 1'b1, "R1 cmd_ready", cmd_ready, 1);
      @(negedge clk);

      send(K_WR, 1, 5, 0, s);                            // R2, R7
      chk(hdr_kind == 2'(K_WR) && hdr_last, "R2 write header", hdr_kind, K_WR);

      // R4: three reads to the same node go out back to back
      for (int i = 0; i < 3; i++) begin
         step(1, K_RD, 2, 0, 0, a);
         chk(a, "R4 same-dest read", a, 1);
      end
      // R5: read to another node waits for all three completions
      send(K_RD, 5, 0, 1, s);
      chk(s == 3, "R5 stall cycles", s, 3);
      idle(3, 1);

      // R9: saturation at MO
      for (int i = 0; i < MO; i++) step(1, K_RD, 3, 0, 0, a);
      step(1, K_RD, 3, 0, 0, a);
      chk(!a, "R9 read at limit", a, 0);
      step(1, K_WR, 3, 0, 0, a);
      chk(a, "R9 write unaffected", a, 1);
      send(K_RD, 3, 0, 1, s);
      chk(s == 1, "R9 release cycles", s, 1);
      idle(8, 1);

      // R6: burst write of four packets
      send(K_BWR, 4, 3, 0, s);
      chk(hdr_hold == 1'b1, "R6 first hold", hdr_hold, 1);
      step(1, K_WR, 4, 0, 0, a);
      chk(!a, "R3 busy during burst", a, 0);
      idle(3, 0);
      // R3: single read ignores length
      send(K_RD, 1, 5, 0, s);
      vcount = 0;
      idle(3, 1);
      chk(vcount == 0, "R3 single packet", vcount, 0);

      // R8: second burst read waits for the first flow to drain
      send(K_BRD, 6, 2, 0, s);
      idle(2, 0);
      send(K_BRD, 6, 1, 1, s);
      chk(s == 3, "R8 stall cycles", s, 3);
      idle(6, 1);

      // R9: long burst read pauses at the limit, resumes on completions
      send(K_BRD, 7, 7, 0, s);
      vcount = 0;
      idle(6, 0);
      chk(vcount == MO - 1, "R9 burst pause", vcount, MO - 1);
      idle(14, 1);

      // R10: completion at zero is ignored
      idle(2, 1);
      send(K_RD, 2, 0, 0, s);
      send(K_RD, 3, 0, 1, s);
      chk(s == 1, "R10 no underflow", s, 1);
      idle(4, 1);

      // mixed random traffic compared to the model
      for (int i = 0; i < 1500; i++) begin
         step($urandom_range(0, 2) != 0, $urandom_range(0, 3), $urandom_range(0, 3),
              $urandom_range(0, 7), $urandom_range(0, 9) < 3, a);
      end
      idle(40, 1);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule